// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block turns the 16-bit requester ID carried by an incoming PCIe transaction (bus, device and function) into a stream ID. An IOMMU and an MSI translation service both use that stream ID. The table has 32 entries. Each entry holds a valid flag, a requester ID, a 16-bit match mask, a 6-bit stream ID and a 3-bit DAC identifier.

Software reaches the entries indirectly. It writes a staging pair of data registers, then writes a control word that names an entry. That write either copies the staging pair into the entry or copies the entry back into the staging pair, so the entry can be read back.

The lookup port takes one requester ID per cycle. It returns a registered hit flag and an 8-bit result: a fixed 2-bit controller identifier placed above the stored 6-bit stream ID.

Top module: `rid_stream_map`

## Requirements
- R1: After reset every entry is invalid, the control and both data registers read zero, and lookups miss.
- R2: The control register sits at offset 0x008. Bits [4:0] hold the entry index and bit 16 is the direction bit. A read returns exactly those two fields, and every other bit reads zero.
- R3: Data register 1 sits at offset 0x00C. Its fields are the valid flag in bit 31, the DAC identifier in bits [10:8] and the stream ID in bits [5:0]. Other bits read zero. Stream ID bits above bit 5 are dropped, so writing 0x7F to the field stores 0x3F.
- R4: Data register 2 sits at offset 0x010. It holds the requester ID in bits [31:16] and the match mask in bits [15:0].
- R5: Writing the control register with bit 16 set copies the addressed entry into both data registers.
- R6: Writing the control register with bit 16 clear copies both data registers into the addressed entry. No other write changes any entry.
- R7: An entry matches when it is valid and it agrees with the incoming requester ID on every bit where its mask is 1. A mask of 0xFFFF demands an exact match, and a mask of 0x0000 matches every ID.
- R8: When several entries match, the entry with the lowest index supplies the result.
- R9: The result appears one clock after a request. On a hit, res_hit is 1 and res_sid is {CTRL_ID, stream ID}, with CTRL_ID defaulting to 2'b10. On a miss, or when there is no request, res_hit is 0 and res_sid is 0.
- R10: Writing zero to both data registers and then committing them invalidates an entry, so it no longer matches.
- R11: A lookup issued in the same cycle as a commit sees the table as it was before the commit. Lookups from the next cycle onward see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| lk_valid | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to translate |
| res_hit | output | 1 | Registered hit flag |
| res_sid | output | 8 | Registered controller ID and stream ID |

## Verification
The hardest case to reach from the ports is a commit and a lookup landing in the same cycle on the same requester ID. In that cycle the old and the new table contents would give different answers. The bench first primes the data registers, then raises the commit write and the lookup on one falling edge. A catch-all entry at a higher index answers that first lookup. The newly committed lower-index entry answers the lookup one cycle later. Overlapping masked entries are set up in the same way, so that priority decides the result. A random phase runs afterwards against the bench's cycle model.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
   localparam int unsigned REG_W       = 32;
   localparam logic [11:0] OFF_CTRL    = 12'h008;
   localparam logic [11:0] OFF_DATA1   = 12'h00C;
   localparam logic [11:0] OFF_DATA2   = 12'h010;
   localparam int unsigned CTL_RD_BIT  = 16;
   localparam int unsigned CTL_IDX_W   = 5;
   localparam int unsigned D1_VLD_BIT  = 31;
   localparam int unsigned D1_DAC_LSB  = 8;
   localparam int unsigned D2_RID_LSB  = 16;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_DATA1,
      SEL_DATA2
   } reg_sel_e;
endpackage

// File: rtl/rsm_regs.sv
module rsm_regs
   import rsm_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned SID_W   = 6,
   parameter int unsigned DAC_W   = 3,
   parameter int unsigned RID_W   = 16,
   parameter int unsigned ADDR_W  = 12,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wen,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic [REG_W-1:0]              cfg_wdata,
   output logic [REG_W-1:0]              cfg_rdata,
   output logic [ENTRIES-1:0]            ent_vld,
   output logic [ENTRIES-1:0][SID_W-1:0] ent_sid,
   output logic [ENTRIES-1:0][RID_W-1:0] ent_rid,
   output logic [ENTRIES-1:0][RID_W-1:0] ent_msk
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_DATA1 = ADDR_W'(OFF_DATA1);
   localparam logic [ADDR_W-1:0] A_DATA2 = ADDR_W'(OFF_DATA2);

   reg_sel_e                 wsel;
   reg_sel_e                 rsel;
   logic                     ctl_wr;
   logic                     ctl_rd_req;
   logic [CTL_IDX_W-1:0]     wr_idx;
   logic                     wr_in_range;
   logic [IDX_W-1:0]         wr_ptr;

   logic [CTL_IDX_W-1:0]     ctl_idx_q;
   logic                     ctl_rd_q;
   logic                     d1_vld_q;
   logic [DAC_W-1:0]         d1_dac_q;
   logic [SID_W-1:0]         d1_sid_q;
   logic [RID_W-1:0]         d2_rid_q;
   logic [RID_W-1:0]         d2_msk_q;
   logic [ENTRIES-1:0][DAC_W-1:0] ent_dac;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == A_CTRL)       return SEL_CTRL;
      else if (a == A_DATA1) return SEL_DATA1;
      else if (a == A_DATA2) return SEL_DATA2;
      else                   return SEL_NONE;
   endfunction

   always_comb begin
      wsel        = decode(cfg_addr);
      rsel        = wsel;
      ctl_wr      = cfg_wen && (wsel == SEL_CTRL);
      ctl_rd_req  = cfg_wdata[CTL_RD_BIT];
      wr_idx      = cfg_wdata[CTL_IDX_W-1:0];
      wr_in_range = (32'(wr_idx) < ENTRIES);
      wr_ptr      = wr_idx[IDX_W-1:0];
   end

   // control register and staging data registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_idx_q <= '0;
         ctl_rd_q  <= 1'b0;
         d1_vld_q  <= 1'b0;
         d1_dac_q  <= '0;
         d1_sid_q  <= '0;
         d2_rid_q  <= '0;
         d2_msk_q  <= '0;
      end else if (cfg_wen) begin
         unique case (wsel)
            SEL_CTRL: begin
               ctl_idx_q <= wr_idx;
               ctl_rd_q  <= ctl_rd_req;
               if (ctl_rd_req) begin
                  if (wr_in_range) begin
                     d1_vld_q <= ent_vld[wr_ptr];
                     d1_dac_q <= ent_dac[wr_ptr];
                     d1_sid_q <= ent_sid[wr_ptr];
                     d2_rid_q <= ent_rid[wr_ptr];
                     d2_msk_q <= ent_msk[wr_ptr];
                  end else begin
                     d1_vld_q <= 1'b0;
                     d1_dac_q <= '0;
                     d1_sid_q <= '0;
                     d2_rid_q <= '0;
                     d2_msk_q <= '0;
                  end
               end
            end
            SEL_DATA1: begin
               d1_vld_q <= cfg_wdata[D1_VLD_BIT];
               d1_dac_q <= cfg_wdata[D1_DAC_LSB +: DAC_W];
               d1_sid_q <= cfg_wdata[SID_W-1:0];
            end
            SEL_DATA2: begin
               d2_rid_q <= cfg_wdata[D2_RID_LSB +: RID_W];
               d2_msk_q <= cfg_wdata[RID_W-1:0];
            end
            default: ;
         endcase
      end
   end

   // entry storage, one commit port per entry
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic commit_here;
      assign commit_here = ctl_wr && !ctl_rd_req &&
                           (wr_idx == CTL_IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vld[e] <= 1'b0;
            ent_dac[e] <= '0;
            ent_sid[e] <= '0;
            ent_rid[e] <= '0;
            ent_msk[e] <= '0;
         end else if (commit_here) begin
            ent_vld[e] <= d1_vld_q;
            ent_dac[e] <= d1_dac_q;
            ent_sid[e] <= d1_sid_q;
            ent_rid[e] <= d2_rid_q;
            ent_msk[e] <= d2_msk_q;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (rsel)
         SEL_CTRL: begin
            cfg_rdata[CTL_IDX_W-1:0] = ctl_idx_q;
            cfg_rdata[CTL_RD_BIT]    = ctl_rd_q;
         end
         SEL_DATA1: begin
            cfg_rdata[D1_VLD_BIT]             = d1_vld_q;
            cfg_rdata[D1_DAC_LSB +: DAC_W]    = d1_dac_q;
            cfg_rdata[SID_W-1:0]              = d1_sid_q;
         end
         SEL_DATA2: begin
            cfg_rdata[D2_RID_LSB +: RID_W]    = d2_rid_q;
            cfg_rdata[RID_W-1:0]              = d2_msk_q;
         end
         default: ;
      endcase
   end

   assert_load_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_rd_req && wr_in_range) |=>
         (d1_vld_q == $past(ent_vld[wr_ptr])) &&
         (d2_rid_q == $past(ent_rid[wr_ptr])) &&
         (d1_sid_q == $past(ent_sid[wr_ptr])));

   assert_commit_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_rd_req && wr_in_range) |=>
         (ent_vld[$past(wr_ptr)] == $past(d1_vld_q)) &&
         (ent_rid[$past(wr_ptr)] == $past(d2_rid_q)) &&
         (ent_msk[$past(wr_ptr)] == $past(d2_msk_q)));

   assert_entries_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && !ctl_rd_req) |=>
         $stable(ent_vld) && $stable(ent_rid) && $stable(ent_msk) &&
         $stable(ent_sid));
endmodule

// File: rtl/rsm_match.sv
module rsm_match #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned RID_W   = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ENTRIES-1:0]            ent_vld,
   input  logic [ENTRIES-1:0][RID_W-1:0] ent_rid,
   input  logic [ENTRIES-1:0][RID_W-1:0] ent_msk,
   input  logic [RID_W-1:0]              lk_rid,
   output logic [ENTRIES-1:0]            hits
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic [RID_W-1:0] diff;
      assign diff    = (ent_rid[e] ^ lk_rid) & ent_msk[e];
      assign hits[e] = ent_vld[e] && (diff == '0);
   end

   assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hits & ~ent_vld) == '0);

   assert_open_mask_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld[0] && ent_msk[0] == '0) |-> hits[0]);
endmodule

// File: rtl/rsm_pick.sv
module rsm_pick #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned SID_W   = 6,
   parameter int unsigned CID_W   = 2,
   parameter logic [CID_W-1:0] CTRL_ID = '0,
   localparam int unsigned OUT_W  = CID_W + SID_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          lk_valid,
   input  logic [ENTRIES-1:0]            hits,
   input  logic [ENTRIES-1:0][SID_W-1:0] ent_sid,
   output logic                          res_hit,
   output logic [OUT_W-1:0]              res_sid
);
   logic [ENTRIES-1:0] grant;
   logic [SID_W-1:0]   sid_sel;
   logic               any_hit;

   // isolate lowest set bit: lowest index wins
   assign grant   = hits & (~hits + ENTRIES'(1));
   assign any_hit = |hits;

   always_comb begin
      sid_sel = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         sid_sel = sid_sel | ({SID_W{grant[e]}} & ent_sid[e]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit <= 1'b0;
         res_sid <= '0;
      end else if (lk_valid && any_hit) begin
         res_hit <= 1'b1;
         res_sid <= {CTRL_ID, sid_sel};
      end else begin
         res_hit <= 1'b0;
         res_sid <= '0;
      end
   end

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any_hit == (grant != '0)));

   assert_hit_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> $past(lk_valid));

   assert_miss_is_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_sid == '0));

   assert_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_sid[OUT_W-1 -: CID_W] == CTRL_ID));
endmodule

// File: rtl/rid_stream_map.sv
module rid_stream_map
   import rsm_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned SID_W   = 6,
   parameter int unsigned DAC_W   = 3,
   parameter int unsigned RID_W   = 16,
   parameter int unsigned CID_W   = 2,
   parameter logic [CID_W-1:0] CTRL_ID = 2'b10,
   parameter int unsigned ADDR_W  = 12,
   localparam int unsigned OUT_W  = CID_W + SID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wen,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              lk_valid,
   input  logic [RID_W-1:0]  lk_rid,
   output logic              res_hit,
   output logic [OUT_W-1:0]  res_sid
);
   if (ENTRIES < 2 || ENTRIES > (1 << CTL_IDX_W)) begin : g_bad_entries
      $error("ENTRIES must lie between 2 and 32");
   end
   if (SID_W < 1 || SID_W > D1_DAC_LSB) begin : g_bad_sid
      $error("SID_W must fit below the DAC field");
   end
   if (DAC_W < 1 || D1_DAC_LSB + DAC_W > D1_VLD_BIT) begin : g_bad_dac
      $error("DAC_W must fit below the valid bit");
   end
   if (RID_W < 1 || RID_W > D2_RID_LSB) begin : g_bad_rid
      $error("RID_W must fit in a half word");
   end
   if (ADDR_W < 5 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must cover the register offsets");
   end

   logic [ENTRIES-1:0]            ent_vld;
   logic [ENTRIES-1:0][SID_W-1:0] ent_sid;
   logic [ENTRIES-1:0][RID_W-1:0] ent_rid;
   logic [ENTRIES-1:0][RID_W-1:0] ent_msk;
   logic [ENTRIES-1:0]            hits;

   rsm_regs #(
      .ENTRIES (ENTRIES),
      .SID_W   (SID_W),
      .DAC_W   (DAC_W),
      .RID_W   (RID_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wen   (cfg_wen),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .ent_vld   (ent_vld),
      .ent_sid   (ent_sid),
      .ent_rid   (ent_rid),
      .ent_msk   (ent_msk)
   );

   rsm_match #(
      .ENTRIES (ENTRIES),
      .RID_W   (RID_W)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .ent_vld (ent_vld),
      .ent_rid (ent_rid),
      .ent_msk (ent_msk),
      .lk_rid  (lk_rid),
      .hits    (hits)
   );

   rsm_pick #(
      .ENTRIES (ENTRIES),
      .SID_W   (SID_W),
      .CID_W   (CID_W),
      .CTRL_ID (CTRL_ID)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_valid (lk_valid),
      .hits     (hits),
      .ent_sid  (ent_sid),
      .res_hit  (res_hit),
      .res_sid  (res_sid)
   );
endmodule

// File: tb/rid_stream_map_bench.sv
module rid_stream_map_bench;
   localparam int CLK_P = 10;
   localparam logic [11:0] A_CTL = 12'h008;
   localparam logic [11:0] A_D1  = 12'h00C;
   localparam logic [11:0] A_D2  = 12'h010;
   localparam logic [1:0]  CID   = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wen = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_valid = 1'b0;
   logic [15:0] lk_rid = '0;
   logic        res_hit;
   logic [7:0]  res_sid;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_on = 0;

   always #(CLK_P/2) clk = ~clk;

   rid_stream_map u_rid_stream_map (
      .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
      .lk_rid(lk_rid), .res_hit(res_hit), .res_sid(res_sid)
   );

   // behavioural reference model
   bit          m_vld [32];
   logic [2:0]  m_dac [32];
   logic [5:0]  m_sid [32];
   logic [15:0] m_rid [32];
   logic [15:0] m_msk [32];
   logic [4:0]  m_idx;
   bit          m_rd;
   bit          m_d1v;
   logic [2:0]  m_d1dac;
   logic [5:0]  m_d1sid;
   logic [15:0] m_d2rid, m_d2msk;
   bit          exp_hit;
   logic [7:0]  exp_sid;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) begin
            m_vld[i] = 0; m_dac[i] = 0; m_sid[i] = 0; m_rid[i] = 0; m_msk[i] = 0;
         end
         m_idx = 0; m_rd = 0; m_d1v = 0; m_d1dac = 0; m_d1sid = 0;
         m_d2rid = 0; m_d2msk = 0; exp_hit = 0; exp_sid = 0;
      end else begin
         bit h;
         logic [7:0] s;
         h = 0; s = 0;
         if (lk_valid) begin
            for (int i = 0; i < 32; i++) begin
               if (!h && m_vld[i] && (((m_rid[i] ^ lk_rid) & m_msk[i]) == 16'h0)) begin
                  h = 1; s = {CID, m_sid[i]};
               end
            end
         end
         exp_hit = h; exp_sid = s;
         if (cfg_wen) begin
            if (cfg_addr == A_D1) begin
               m_d1v = cfg_wdata[31]; m_d1dac = cfg_wdata[10:8]; m_d1sid = cfg_wdata[5:0];
            end else if (cfg_addr == A_D2) begin
               m_d2rid = cfg_wdata[31:16]; m_d2msk = cfg_wdata[15:0];
            end else if (cfg_addr == A_CTL) begin
               int k;
               k = int'(cfg_wdata[4:0]);
               m_idx = cfg_wdata[4:0]; m_rd = cfg_wdata[16];
               if (m_rd) begin
                  m_d1v = m_vld[k]; m_d1dac = m_dac[k]; m_d1sid = m_sid[k];
                  m_d2rid = m_rid[k]; m_d2msk = m_msk[k];
               end else begin
                  m_vld[k] = m_d1v; m_dac[k] = m_d1dac; m_sid[k] = m_d1sid;
                  m_rid[k] = m_d2rid; m_msk[k] = m_d2msk;
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // compare with the model on every clock
   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         check(res_hit == exp_hit, "R9 model hit", 32'(res_hit), 32'(exp_hit));
         check(res_sid == exp_sid, "R8 model sid", 32'(res_sid), 32'(exp_sid));
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wen = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(cfg_rdata == e, tag, cfg_rdata, e);
   endtask

   task automatic look(input logic [15:0] r, input bit eh, input logic [7:0] es,
                       input string tag);
      @(negedge clk);
      lk_valid = 1'b1; lk_rid = r;
      @(negedge clk);
      check(res_hit == eh && res_sid == es, tag, {23'h0, res_hit, res_sid}, {23'h0, eh, es});
      lk_valid = 1'b0;
   endtask

   task automatic prog(input int idx, input logic [31:0] d1, input logic [31:0] d2);
      wr(A_D1, d1);
      wr(A_D2, d2);
      wr(A_CTL, 32'(idx));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset state
      rd_chk(A_CTL, 32'h0, "R1 ctrl after reset");
      rd_chk(A_D1, 32'h0, "R1 data1 after reset");
      rd_chk(A_D2, 32'h0, "R1 data2 after reset");
      look(16'h0000, 0, 8'h00, "R1 lookup misses after reset");
      // R3 / R4 field layout
      wr(A_D1, 32'hFFFF_FFFF);
      rd_chk(A_D1, 32'h8000_073F, "R3 data1 fields and sid truncation");
      wr(A_D2, 32'h1234_ABCD);
      rd_chk(A_D2, 32'h1234_ABCD, "R4 data2 fields");
      // R2 control readback, R5 load of empty entry 31
      wr(A_CTL, 32'hFFFF_FFFF);
      rd_chk(A_CTL, 32'h0001_001F, "R2 ctrl readback");
      rd_chk(A_D1, 32'h0, "R5 load empty entry data1");
      rd_chk(A_D2, 32'h0, "R5 load empty entry data2");
      // entries
      prog(3, 32'h8000_057F, 32'h0108_FFFF);
      look(16'h0108, 1, 8'hBF, "R7 exact match, R9 prefix");
      look(16'h0109, 0, 8'h00, "R7 exact mask rejects");
      wr(A_CTL, 32'h0001_0003);
      rd_chk(A_D1, 32'h8000_053F, "R5 load entry data1");
      rd_chk(A_D2, 32'h0108_FFFF, "R5 load entry data2");
      rd_chk(A_CTL, 32'h0001_0003, "R2 ctrl read after load");
      prog(7, 32'h8000_0011, 32'h0200_FF00);
      look(16'h02AB, 1, 8'h91, "R7 partial mask match");
      look(16'h03AB, 0, 8'h00, "R7 partial mask miss");
      prog(10, 32'h8000_0022, 32'h0000_0000);
      look(16'h02AB, 1, 8'h91, "R8 lower index wins over catch-all");
      look(16'h0108, 1, 8'hBF, "R8 entry 3 wins");
      look(16'h5555, 1, 8'hA2, "R7 zero mask matches any");
      // R9 no request
      @(negedge clk); lk_rid = 16'h0108; lk_valid = 1'b0;
      @(negedge clk);
      check(res_hit == 1'b0 && res_sid == 8'h0, "R9 no request no hit",
            {23'h0, res_hit, res_sid}, 32'h0);
      // R11 same-cycle commit and lookup
      wr(A_D1, 32'h8000_0005);
      wr(A_D2, 32'h0777_FFFF);
      @(negedge clk);
      cfg_wen = 1'b1; cfg_addr = A_CTL; cfg_wdata = 32'h0000_0001;
      lk_valid = 1'b1; lk_rid = 16'h0777;
      @(negedge clk);
      cfg_wen = 1'b0;
      check(res_hit && res_sid == 8'hA2, "R11 lookup sees old table",
            {23'h0, res_hit, res_sid}, 32'h1A2);
      @(negedge clk);
      check(res_hit && res_sid == 8'h85, "R11 next lookup sees commit",
            {23'h0, res_hit, res_sid}, 32'h185);
      lk_valid = 1'b0;
      // R10 invalidation
      prog(3, 32'h0, 32'h0);
      look(16'h0108, 1, 8'hA2, "R10 invalidated entry falls through");
      wr(A_CTL, 32'h0001_0003);
      rd_chk(A_D1, 32'h0, "R10 invalidated entry reads zero");
      prog(10, 32'h0, 32'h0);
      look(16'h5555, 0, 8'h00, "R10 invalidated catch-all misses");
      // random phase against the model
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         cfg_wen = 1'b0; lk_valid = 1'b0;
         case ($urandom_range(0, 4))
            0: begin cfg_wen = 1'b1; cfg_addr = A_D1; cfg_wdata = $urandom; end
            1: begin cfg_wen = 1'b1; cfg_addr = A_D2;
                     cfg_wdata = {4'h0, 12'($urandom_range(0, 7)), 16'($urandom) | 16'hFFF0}; end
            2: begin cfg_wen = 1'b1; cfg_addr = A_CTL;
                     cfg_wdata = {15'h0, 1'($urandom), 11'h0, 5'($urandom)}; end
            default: ;
         endcase
         lk_valid = 1'($urandom);
         lk_rid = {4'h0, 12'($urandom_range(0, 7))} | 16'($urandom_range(0, 3) << 12);
      end
      @(negedge clk);
      cfg_wen = 1'b0; lk_valid = 1'b0;
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule